// File: doc/BRIEF.md
# Carrier-Gated Asynchronous Serial Receiver

This block turns an asynchronous serial line into parallel characters. The receive clock arrives as a one-cycle enable pulse, `rxc_tick`, in the system clock domain, and each pulse stands for one rising edge of the receive clock. A two-bit rate code gives the ratio of tick rate to bit rate: one tick per bit, sixteen per bit or sixty-four per bit. The serial input idles high (mark). A low level (space) starts a character. Every character has one start bit, eight data bits sent least significant bit first, and one stop bit.

The finished character is placed in a holding register together with a ready flag, a framing-error flag and an overrun flag, and a status or interrupt stage reads them. Reception runs only while the receiver enable is high and the active-low carrier input `dcd_n` is low. If carrier is lost partway through a character, the receiver drops that character and waits for a new start bit. The serial input is taken to be synchronous to `clk`.

Top module: `carrier_gated_rx`

## Requirements
- R1: While reset is held and right after it is released, `rx_ready`, `frame_err` and `overrun` are low.
- R2: With `rate_sel` = 2'b00 (1x), the tick that sees the line low in idle is taken as the start bit. The next eight ticks each sample one data bit, and the tick after those samples the stop bit.
- R3: With `rate_sel` = 2'b01 (16x), a start is confirmed only if the line is still low on the 8th tick after the tick that first saw it low. After that, the line is sampled every 16 ticks: eight data bits, then the stop bit.
- R4: With `rate_sel` = 2'b10 or 2'b11 (64x), start is confirmed on the 32nd tick after detection, and the line is sampled every 64 ticks after that.
- R5: A low pulse that has ended by the confirmation tick is rejected. No character is produced, and the receiver goes back to looking for a start bit.
- R6: On the tick that samples the stop bit, the character is loaded into `rx_data` and `rx_ready` goes high on the next clock. The first data bit received lands in bit 0.
- R7: `frame_err` is updated with each completed character. It is 1 if the stop bit was sampled low and 0 if it was sampled high.
- R8: When a character completes while `rx_ready` is already high and `rd_strobe` is low, `overrun` is set to 1 and `rx_data` takes the new character. When a character completes without that condition, `overrun` is set to 0.
- R9: `rd_strobe` clears `rx_ready` on the next clock, unless a character completes in the same cycle.
- R10: While `rx_en` is low, `rx_ready`, `frame_err` and `overrun` are cleared, any partial character is dropped, and nothing is received.
- R11: While `dcd_n` is high, nothing is received. Carrier lost partway through a character drops the partial character and sends the receiver back to looking for a start bit.
- R12: Receiver state changes only on clocks where `rxc_tick` is high, except when it is cleared by `rx_en` or carrier loss.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxc_tick | input | 1 | Receive clock enable, one pulse per receive clock rising edge |
| rate_sel | input | 2 | Ticks per bit: 00 = 1, 01 = 16, 1x = 64 |
| rx_en | input | 1 | Receiver enable |
| dcd_n | input | 1 | Carrier detect, active low |
| rxd | input | 1 | Serial data, high = mark |
| rd_strobe | input | 1 | Holding register read pulse |
| rx_data | output | DATA_W | Received character |
| rx_ready | output | 1 | Character waiting in the holding register |
| frame_err | output | 1 | Last character had a low stop bit |
| overrun | output | 1 | Last character replaced one that had not been read |

## Verification
A bad bit-timing counter or a bad start-confirmation count makes the receiver sample the wrong part of each bit. Because the bench uses random characters and random gaps between ticks, `rx_data` then differs from the character sent, and this shows within one character time. A framing or overrun state that is wrong shows on the flag pins as soon as the stop bit is sampled. A receiver that keeps its state through a carrier loss or a disable shows a wrong character or a wrong ready flag when the following clean character completes. False starts and idle carrier are checked by confirming that `rx_ready` stays low, and then by receiving one good character.

// File: rtl/cgr_pkg.sv
package cgr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_e;

  localparam logic [1:0] RATE_X1  = 2'b00;
  localparam logic [1:0] RATE_X16 = 2'b01;

endpackage

// File: rtl/cgr_rate_decode.sv
module cgr_rate_decode
  import cgr_pkg::*;
#(
  parameter int MID_DIV  = 16,
  parameter int FAST_DIV = 64,
  parameter int CNT_W    = $clog2(FAST_DIV)
) (
  input  logic [1:0]       rate_sel,
  output logic [CNT_W-1:0] bit_last,
  output logic [CNT_W-1:0] half_last,
  output logic             single_x
);

  localparam logic [CNT_W-1:0] MID_BIT   = CNT_W'(MID_DIV - 1);
  localparam logic [CNT_W-1:0] MID_HALF  = CNT_W'(MID_DIV / 2 - 1);
  localparam logic [CNT_W-1:0] FAST_BIT  = CNT_W'(FAST_DIV - 1);
  localparam logic [CNT_W-1:0] FAST_HALF = CNT_W'(FAST_DIV / 2 - 1);

  always_comb begin
    single_x  = 1'b0;
    bit_last  = FAST_BIT;
    half_last = FAST_HALF;
    if (rate_sel == RATE_X1) begin
      single_x  = 1'b1;
      bit_last  = '0;
      half_last = '0;
    end else if (rate_sel == RATE_X16) begin
      bit_last  = MID_BIT;
      half_last = MID_HALF;
    end
  end

endmodule

// File: rtl/cgr_frame_fsm.sv
module cgr_frame_fsm
  import cgr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 6,
  parameter int BIT_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxc_tick,
  input  logic              rx_en,
  input  logic              dcd_n,
  input  logic              rxd,
  input  logic [CNT_W-1:0]  bit_last,
  input  logic [CNT_W-1:0]  half_last,
  input  logic              single_x,
  output logic              frame_done,
  output logic              stop_level,
  output logic [DATA_W-1:0] frame_bits,
  output rx_state_e         state_out
);

  localparam logic [BIT_W-1:0] LAST_IDX = BIT_W'(DATA_W - 1);

  rx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  sub_q, sub_d;
  logic [BIT_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              kill;
  logic              adv;

  assign kill = ~rx_en | dcd_n;
  assign adv  = rxc_tick & ~kill;

  always_comb begin
    state_d    = state_q;
    sub_d      = sub_q;
    idx_d      = idx_q;
    sh_d       = sh_q;
    frame_done = 1'b0;
    stop_level = rxd;
    if (kill) begin
      state_d = ST_IDLE;
      sub_d   = '0;
      idx_d   = '0;
    end else if (adv) begin
      unique case (state_q)
        ST_IDLE: begin
          if (!rxd) begin
            sub_d   = '0;
            idx_d   = '0;
            state_d = single_x ? ST_DATA : ST_START;
          end
        end
        ST_START: begin
          if (sub_q == half_last) begin
            sub_d   = '0;
            state_d = rxd ? ST_IDLE : ST_DATA;
          end else begin
            sub_d = sub_q + 1'b1;
          end
        end
        ST_DATA: begin
          if (sub_q == bit_last) begin
            sub_d = '0;
            sh_d  = {rxd, sh_q[DATA_W-1:1]};
            if (idx_q == LAST_IDX) begin
              state_d = ST_STOP;
            end else begin
              idx_d = idx_q + 1'b1;
            end
          end else begin
            sub_d = sub_q + 1'b1;
          end
        end
        ST_STOP: begin
          if (sub_q == bit_last) begin
            sub_d      = '0;
            frame_done = 1'b1;
            state_d    = ST_IDLE;
          end else begin
            sub_d = sub_q + 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sub_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
    end else begin
      state_q <= state_d;
      sub_q   <= sub_d;
      idx_q   <= idx_d;
      sh_q    <= sh_d;
    end
  end

  assign frame_bits = sh_q;
  assign state_out  = state_q;

endmodule

// File: rtl/cgr_hold_reg.sv
module cgr_hold_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              frame_done,
  input  logic              stop_level,
  input  logic [DATA_W-1:0] frame_bits,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              frame_err,
  output logic              overrun
);

  logic [DATA_W-1:0] data_q, data_d;
  logic              rdy_q, rdy_d;
  logic              fe_q, fe_d;
  logic              ov_q, ov_d;
  logic              load_en;

  assign load_en = rx_en & frame_done;

  always_comb begin
    data_d = data_q;
    rdy_d  = rdy_q;
    fe_d   = fe_q;
    ov_d   = ov_q;
    if (!rx_en) begin
      rdy_d = 1'b0;
      fe_d  = 1'b0;
      ov_d  = 1'b0;
    end else if (load_en) begin
      data_d = frame_bits;
      rdy_d  = 1'b1;
      fe_d   = ~stop_level;
      ov_d   = rdy_q & ~rd_strobe;
    end else if (rd_strobe) begin
      rdy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      rdy_q  <= 1'b0;
      fe_q   <= 1'b0;
      ov_q   <= 1'b0;
    end else begin
      data_q <= data_d;
      rdy_q  <= rdy_d;
      fe_q   <= fe_d;
      ov_q   <= ov_d;
    end
  end

  assign rx_data   = data_q;
  assign rx_ready  = rdy_q;
  assign frame_err = fe_q;
  assign overrun   = ov_q;

endmodule

// File: rtl/carrier_gated_rx.sv
module carrier_gated_rx
  import cgr_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int MID_DIV  = 16,
  parameter int FAST_DIV = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxc_tick,
  input  logic [1:0]        rate_sel,
  input  logic              rx_en,
  input  logic              dcd_n,
  input  logic              rxd,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              frame_err,
  output logic              overrun
);

  localparam int CNT_W = $clog2(FAST_DIV);
  localparam int BIT_W = $clog2(DATA_W);

  logic [1:0]        rst_pipe;
  logic              rst_core_n;
  logic [CNT_W-1:0]  bit_last;
  logic [CNT_W-1:0]  half_last;
  logic              single_x;
  logic              frame_done;
  logic              stop_level;
  logic [DATA_W-1:0] frame_bits;
  rx_state_e         fsm_state;
  logic              fsm_idle;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_core_n = rst_pipe[1];

  cgr_rate_decode #(
    .MID_DIV  (MID_DIV),
    .FAST_DIV (FAST_DIV),
    .CNT_W    (CNT_W)
  ) u_rate (
    .rate_sel  (rate_sel),
    .bit_last  (bit_last),
    .half_last (half_last),
    .single_x  (single_x)
  );

  cgr_frame_fsm #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .BIT_W  (BIT_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .rxc_tick   (rxc_tick),
    .rx_en      (rx_en),
    .dcd_n      (dcd_n),
    .rxd        (rxd),
    .bit_last   (bit_last),
    .half_last  (half_last),
    .single_x   (single_x),
    .frame_done (frame_done),
    .stop_level (stop_level),
    .frame_bits (frame_bits),
    .state_out  (fsm_state)
  );

  assign fsm_idle = (fsm_state == ST_IDLE);

  cgr_hold_reg #(
    .DATA_W (DATA_W)
  ) u_hold (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .rx_en      (rx_en),
    .frame_done (frame_done),
    .stop_level (stop_level),
    .frame_bits (frame_bits),
    .rd_strobe  (rd_strobe),
    .rx_data    (rx_data),
    .rx_ready   (rx_ready),
    .frame_err  (frame_err),
    .overrun    (overrun)
  );

endmodule

// File: rtl/carrier_gated_rx_chk.sv
module carrier_gated_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rxc_tick,
  input logic       rx_en,
  input logic       dcd_n,
  input logic       rd_strobe,
  input logic       rx_ready,
  input logic       frame_err,
  input logic       overrun,
  input logic       frame_done,
  input logic       stop_level,
  input logic       fsm_idle,
  input logic [1:0] fsm_state
);

  // R6
  ready_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> rx_ready);

  // R7
  ferr_on_low_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !stop_level) |=> frame_err);

  // R8
  ovr_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(rx_ready));

  // R9
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !frame_done) |=> !rx_ready);

  // R10
  disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!rx_ready && !frame_err && !overrun));

  // R11
  carrier_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dcd_n || !rx_en) |=> fsm_idle);

  // R12
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rxc_tick && rx_en && !dcd_n) |=> $stable(fsm_state));

endmodule

bind carrier_gated_rx carrier_gated_rx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rxc_tick   (rxc_tick),
  .rx_en      (rx_en),
  .dcd_n      (dcd_n),
  .rd_strobe  (rd_strobe),
  .rx_ready   (rx_ready),
  .frame_err  (frame_err),
  .overrun    (overrun),
  .frame_done (frame_done),
  .stop_level (stop_level),
  .fsm_idle   (fsm_idle),
  .fsm_state  (fsm_state)
);

// File: tb/carrier_gated_rx_bench.sv
module carrier_gated_rx_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 8;

  logic              clk;
  logic              rst_n;
  logic              rxc_tick;
  logic [1:0]        rate_sel;
  logic              rx_en;
  logic              dcd_n;
  logic              rxd;
  logic              rd_strobe;
  logic [DATA_W-1:0] rx_data;
  logic              rx_ready;
  logic              frame_err;
  logic              overrun;

  int checks;
  int fails;
  bit finished;

  carrier_gated_rx u_carrier_gated_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .rxc_tick  (rxc_tick),
    .rate_sel  (rate_sel),
    .rx_en     (rx_en),
    .dcd_n     (dcd_n),
    .rxd       (rxd),
    .rd_strobe (rd_strobe),
    .rx_data   (rx_data),
    .rx_ready  (rx_ready),
    .frame_err (frame_err),
    .overrun   (overrun)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int ticks_per_bit(input logic [1:0] r);
    if (r == 2'b00) return 1;
    if (r == 2'b01) return 16;
    return 64;
  endfunction

  function automatic logic exp_ferr(input logic stop_bit);
    return ~stop_bit;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_ticks(input int n);
    for (int k = 0; k < n; k++) begin
      repeat ($urandom % 3) @(negedge clk);
      @(negedge clk);
      rxc_tick = 1'b1;
      @(negedge clk);
      rxc_tick = 1'b0;
    end
  endtask

  task automatic send_char(input logic [7:0] d, input logic stop_bit);
    int f;
    f = ticks_per_bit(rate_sel);
    rxd = 1'b0;
    do_ticks(f);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      do_ticks(f);
    end
    rxd = stop_bit;
    do_ticks((f == 1) ? 1 : f / 2 + 1);
    rxd = 1'b1;
    if (f > 1) do_ticks(f / 2 - 1);
    do_ticks(2);
  endtask

  task automatic read_pulse();
    @(negedge clk);
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] c;
    logic [7:0] c2;
    logic [1:0] rates [3];
    checks    = 0;
    fails     = 0;
    finished  = 1'b0;
    void'($urandom(32'd4171));
    rst_n     = 1'b0;
    rxc_tick  = 1'b0;
    rate_sel  = 2'b01;
    rx_en     = 1'b1;
    dcd_n     = 1'b0;
    rxd       = 1'b1;
    rd_strobe = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 ready in reset", rx_ready, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 ready", rx_ready, 0);
    check("R1 frame_err", frame_err, 0);
    check("R1 overrun", overrun, 0);

    // R2 R3 R4 R6 R7 R9: random characters at each rate
    rates[0] = 2'b00; rates[1] = 2'b01; rates[2] = 2'b10;
    foreach (rates[j]) begin
      rate_sel = rates[j];
      for (int n = 0; n < ((j == 2) ? 3 : 6); n++) begin
        c = 8'($urandom);
        send_char(c, 1'b1);
        check("R2 R3 R4 R6 data", rx_data, c);
        check("R6 ready", rx_ready, 1);
        check("R7 frame_err clear", frame_err, exp_ferr(1'b1));
        check("R8 no overrun", overrun, 0);
        read_pulse();
        check("R9 read clears", rx_ready, 0);
      end
    end

    // R4 rate code 3 also 64x
    rate_sel = 2'b11;
    send_char(8'hA5, 1'b1);
    check("R4 code3 data", rx_data, 8'hA5);
    read_pulse();

    // R7 framing error at 16x and 1x
    rate_sel = 2'b01;
    send_char(8'h3C, 1'b0);
    check("R7 frame_err set", frame_err, exp_ferr(1'b0));
    check("R7 data", rx_data, 8'h3C);
    read_pulse();
    rate_sel = 2'b00;
    send_char(8'hC3, 1'b0);
    check("R7 frame_err 1x", frame_err, 1);
    read_pulse();
    send_char(8'h81, 1'b1);
    check("R7 frame_err recovers", frame_err, 0);
    read_pulse();

    // R8 overrun
    rate_sel = 2'b01;
    c  = 8'($urandom);
    c2 = 8'($urandom);
    send_char(c, 1'b1);
    check("R8 first no overrun", overrun, 0);
    send_char(c2, 1'b1);
    check("R8 overrun set", overrun, 1);
    check("R8 data replaced", rx_data, c2);
    read_pulse();
    send_char(8'h55, 1'b1);
    check("R8 overrun cleared", overrun, 0);
    read_pulse();

    // R5 false start at 16x: low 4 ticks, then high
    rxd = 1'b0;
    do_ticks(4);
    rxd = 1'b1;
    do_ticks(40);
    check("R5 glitch rejected", rx_ready, 0);
    send_char(8'h96, 1'b1);
    check("R5 next char", rx_data, 8'h96);
    read_pulse();

    // R11 carrier high at idle: nothing received
    dcd_n = 1'b1;
    send_char(8'h00, 1'b1);
    dcd_n = 1'b0;
    do_ticks(40);
    check("R11 no carrier", rx_ready, 0);

    // R11 carrier lost mid-character
    rxd = 1'b0;
    do_ticks(16);
    for (int i = 0; i < 3; i++) begin
      rxd = 1'b0;
      do_ticks(16);
    end
    dcd_n = 1'b1;
    do_ticks(4);
    rxd   = 1'b1;
    dcd_n = 1'b0;
    do_ticks(200);
    check("R11 partial dropped", rx_ready, 0);
    send_char(8'h6B, 1'b1);
    check("R11 clean after loss", rx_data, 8'h6B);

    // R10 disable clears flags, then blocks reception
    send_char(8'h11, 1'b0);
    check("R10 pre overrun", overrun, 1);
    @(negedge clk);
    rx_en = 1'b0;
    @(negedge clk);
    check("R10 ready cleared", rx_ready, 0);
    check("R10 flags cleared", {frame_err, overrun}, 0);
    send_char(8'h00, 1'b1);
    check("R10 nothing received", rx_ready, 0);
    rx_en = 1'b1;
    do_ticks(4);
    send_char(8'hE7, 1'b1);
    check("R10 resumes", rx_data, 8'hE7);

    // R12 no ticks: line activity alone does nothing
    read_pulse();
    rxd = 1'b0;
    repeat (300) @(negedge clk);
    rxd = 1'b1;
    do_ticks(40);
    check("R12 no tick no char", rx_ready, 0);

    finish_run();
  end

endmodule